// File: doc/BRIEF.md
# Strobed Output Port Handshake

This block is a byte-wide output port with a two-wire handshake toward a peripheral. A host writes a byte with an active-low write strobe. When the strobe is released, the port latches the byte onto its output lines and pulls an active-low "buffer full" flag low to tell the peripheral that a byte is waiting. The peripheral takes the byte by pulsing an active-low acknowledge. The falling edge of the acknowledge releases the buffer-full flag. The rising edge raises an interrupt request, which asks the host for the next byte.

The write strobe and the acknowledge are asynchronous. Each passes through a two-stage synchronizer clocked by the system clock, and the port reacts only to the edges it detects afterwards. Because only edges matter, an acknowledge held low for many cycles acts exactly like a short one. An interrupt-enable input gates the request. The write data is sampled when the synchronized write edge is detected, so the host keeps it stable for at least three clock cycles after it releases the strobe.

Top module: `strobed_out_port`

## Requirements
- R1: After reset, the output byte is 0x00, the buffer-full flag is 1 (no byte pending) and the interrupt request is 0.
- R2: When the write strobe rises, the byte on the write data input appears on the output lines and the buffer-full flag goes to 0. Both are in place by the third rising clock edge after the strobe rises. After that, the output byte holds even if the write data input changes.
- R3: A rising edge of the write strobe clears the interrupt request.
- R4: A falling edge of the acknowledge sets the buffer-full flag back to 1 and leaves the output byte unchanged.
- R5: A rising edge of the acknowledge raises the interrupt request if the interrupt enable is 1 at that edge.
- R6: The port reacts only to edges. Holding the acknowledge low or high for any number of cycles changes neither the flag nor the request after the edge has taken effect.
- R7: The interrupt output is 0 whenever the interrupt enable is 0. An acknowledge rising edge seen while the enable is 0 leaves no pending request behind.
- R8: A second write before any acknowledge replaces the output byte with the new value, and the buffer-full flag stays 0.
- R9: If a write-strobe rising edge and an acknowledge falling edge are detected in the same cycle, the write wins: the flag ends at 0 and the new byte is on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n_i | input | 1 | Host write strobe, active low, asynchronous |
| wr_data_i | input | DATA_W | Host write data, sampled at the detected strobe release |
| ack_n_i | input | 1 | Peripheral acknowledge, active low, asynchronous |
| int_en_i | input | 1 | Interrupt enable, 1 allows the request |
| port_out_o | output | DATA_W | Latched output byte |
| buf_full_n_o | output | 1 | Buffer-full flag, 0 while a byte is pending |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
The main function is driven through several sequences: a plain write followed by an acknowledge, a write repeated before any acknowledge, an acknowledge held low for tens of cycles, and acknowledge pulses with the enable low and high. The first sequence shows that the flag and the request follow the right edges. The repeated write shows overwrite apart from a queued second byte. The long acknowledge shows edge behaviour apart from level behaviour. The enable pulses show the masking and that no request is left pending. A last case releases the write and lowers the acknowledge at the same instant, which checks that the write has priority.

// File: rtl/spo_pkg.sv
package spo_pkg;

    // Result of edge detection on one synchronized line
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    // Line positions in the synchronized input bundle
    localparam int unsigned LINE_WR  = 0;
    localparam int unsigned LINE_ACK = 1;
    localparam int unsigned N_LINES  = 2;

endpackage

// File: rtl/spo_sync.sv
module spo_sync #(
    parameter int unsigned WIDTH   = 2,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= RST_VAL;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/spo_edge.sv
module spo_edge
    import spo_pkg::*;
#(
    parameter int unsigned WIDTH = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  lvl_i,
    output edge_t [WIDTH-1:0] edge_o
);

    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= prev_d;
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        assign edge_o[i].rise =  lvl_i[i] & ~prev_q[i];
        assign edge_o[i].fall = ~lvl_i[i] &  prev_q[i];
    end

endmodule

// File: rtl/strobed_out_port.sv
module strobed_out_port
    import spo_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              ack_n_i,
    input  logic              int_en_i,
    output logic [DATA_W-1:0] port_out_o,
    output logic              buf_full_n_o,
    output logic              irq_o
);

    localparam logic [N_LINES-1:0] IDLE_LINES = '1;

    typedef struct packed {
        logic [DATA_W-1:0] dout;
        logic              full_n;
        logic              req;
    } state_t;

    state_t state_d, state_q;

    logic [N_LINES-1:0]  raw_lines;
    logic [N_LINES-1:0]  sync_lines;
    edge_t [N_LINES-1:0] line_edge;
    logic wr_rise, ack_fall, ack_rise;

    assign raw_lines[LINE_WR]  = wr_n_i;
    assign raw_lines[LINE_ACK] = ack_n_i;

    spo_sync #(
        .WIDTH   (N_LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IDLE_LINES)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_lines),
        .sync_o  (sync_lines)
    );

    spo_edge #(
        .WIDTH   (N_LINES),
        .RST_VAL (IDLE_LINES)
    ) i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (sync_lines),
        .edge_o (line_edge)
    );

    assign wr_rise  = line_edge[LINE_WR].rise;
    assign ack_fall = line_edge[LINE_ACK].fall;
    assign ack_rise = line_edge[LINE_ACK].rise;

    // Next state: acknowledge edges first, write release last so it wins
    always_comb begin
        state_d = state_q;
        if (ack_fall) begin
            state_d.full_n = 1'b1;
        end
        if (ack_rise && int_en_i) begin
            state_d.req = 1'b1;
        end
        if (!int_en_i) begin
            state_d.req = 1'b0;
        end
        if (wr_rise) begin
            state_d.dout   = wr_data_i;
            state_d.full_n = 1'b0;
            state_d.req    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.dout   <= '0;
            state_q.full_n <= 1'b1;
            state_q.req    <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign port_out_o   = state_q.dout;
    assign buf_full_n_o = state_q.full_n;
    assign irq_o        = state_q.req & int_en_i;

    // ---------------- assertions ----------------
    p_write_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rise |=> (!buf_full_n_o && port_out_o == $past(wr_data_i)));

    p_write_clears_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rise |=> !state_q.req);

    p_ack_fall_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fall && !wr_rise) |=> buf_full_n_o);

    p_out_only_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_rise |=> $stable(port_out_o));

    p_ack_rise_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rise && int_en_i && !wr_rise) |=> state_q.req);

    p_flag_edge_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_rise && !ack_fall) |=> $stable(buf_full_n_o));

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en_i |-> !irq_o);

    p_write_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rise && ack_fall) |=> !buf_full_n_o);

endmodule

// File: tb/test_strobed_out_port.sv
`timescale 1ns/1ps
module test_strobed_out_port;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          ack_n = 1'b1;
    logic          int_en = 1'b0;
    logic [DW-1:0] port_out;
    logic          full_n;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    strobed_out_port #(.DATA_W(DW), .SYNC_STAGES(2)) i_strobed_out_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_n_i       (wr_n),
        .wr_data_i    (wr_data),
        .ack_n_i      (ack_n),
        .int_en_i     (int_en),
        .port_out_o   (port_out),
        .buf_full_n_o (full_n),
        .irq_o        (irq)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic host_write(input logic [DW-1:0] val);
        @(negedge clk);
        wr_data = val;
        wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        settle();
    endtask

    task automatic t_reset();
        check("R1", "out", port_out, 0);
        check("R1", "full_n", full_n, 1);
        check("R1", "irq", irq, 0);
    endtask

    task automatic t_write_then_long_ack();
        host_write(8'hA5);
        check("R2", "out", port_out, 8'hA5);
        check("R2", "full_n", full_n, 0);
        check("R3", "irq", irq, 0);
        wr_data = 8'h3C;
        settle();
        check("R2", "out held", port_out, 8'hA5);
        ack_n = 1'b0;
        settle();
        check("R4", "full_n", full_n, 1);
        check("R4", "out", port_out, 8'hA5);
        repeat (20) @(negedge clk);
        check("R6", "full_n long ack", full_n, 1);
        check("R6", "irq long ack", irq, 0);
        ack_n = 1'b1;
        settle();
        check("R5", "irq", irq, 1);
        repeat (10) @(negedge clk);
        check("R6", "irq held", irq, 1);
        check("R6", "full_n held", full_n, 1);
    endtask

    task automatic t_overwrite();
        host_write(8'h5A);
        check("R3", "irq cleared", irq, 0);
        check("R2", "out", port_out, 8'h5A);
        host_write(8'hC3);
        check("R8", "out", port_out, 8'hC3);
        check("R8", "full_n", full_n, 0);
    endtask

    task automatic t_mask();
        int_en = 1'b0;
        ack_n = 1'b0;
        settle();
        ack_n = 1'b1;
        settle();
        check("R7", "irq masked", irq, 0);
        int_en = 1'b1;
        settle();
        check("R7", "no stale req", irq, 0);
        ack_n = 1'b0;
        settle();
        ack_n = 1'b1;
        settle();
        check("R5", "irq enabled", irq, 1);
        int_en = 1'b0;
        #1;
        check("R7", "irq drop", irq, 0);
        int_en = 1'b1;
        settle();
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        wr_data = 8'h99;
        wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        ack_n = 1'b0;
        settle();
        check("R9", "full_n", full_n, 0);
        check("R9", "out", port_out, 8'h99);
        check("R9", "irq", irq, 0);
        ack_n = 1'b1;
        settle();
        check("R9", "full_n after ack rise", full_n, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        int_en = 1'b1;
        settle();
        t_reset();
        t_write_then_long_ack();
        t_overwrite();
        t_mask();
        t_same_cycle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule